// File: doc/BRIEF.md
# Processor Bus Trace Qualifier

This block sits next to a pipelined 32-bit processor. It turns the processor's bus control and pipeline status lines into qualifier strobes for an external logic analyzer. The analyzer is clocked from the processor clock and stores a sample on each falling edge where `sample_en` is high. Every output changes only on the rising edge, so each output is steady around the falling edge where the analyzer takes its sample. The block separates bus cycles that completed from cycles that were started and then abandoned because an internal cache or holding register supplied the data. It also tags pipeline refills, instruction boundaries and exceptions, so that prefetched operands the execution unit never used can be recognised in the trace. It raises a halt qualifier when the bus stops making progress. Cache reads never appear on the bus. The analyzer can still place them by their low eight address bits, which are not translated. Whenever `abort_flag` pulses, those bits are the local reference for the abandoned access.

The block is built from three state machines.

The bus-cycle machine has these states:
- `CYC_IDLE`: no cycle is in progress.
- `CYC_STARTED`: a cycle start has been seen, but no address strobe yet.
- `CYC_ACTIVE`: the address strobe has been seen and termination is awaited.

Its transitions are:
- idle→started when a cycle start is seen.
- started→active when the strobe arrives without termination.
- started→idle when the strobe and termination arrive together; this is a sampled cycle.
- started→idle or started→started when there is no strobe; this is an aborted cycle, and a new cycle start keeps the machine in started.
- active→idle or active→started on termination.
- active→active while termination is awaited.

The status decoder has these states:
- `ST_QUIET`: status is low.
- `ST_ONE`: status has been high for one clock.
- `ST_MANY`: status has been high for two or more clocks.

Its transitions are:
- quiet→one when status rises.
- one→many when status stays high.
- one→quiet when status falls; this reports a boundary event.
- many→quiet when status falls; this reports an exception event.

The halt watchdog has no states of its own. It counts the clocks spent in `CYC_ACTIVE`.

Top module: `bus_trace_qualifier`

## Requirements
- R1: While `rst` is high, `sample_en`, `abort_flag`, `refill_flag`, `boundary_flag` and `exception_flag` are low, and `halt_flag` is high. All six outputs are registered on the rising edge of `clk`.
- R2: Take a cycle start, an address strobe seen at the following rising edge, and a termination seen while the strobe is still high. Then `sample_en` is high for exactly one clock, the clock after the rising edge where termination was seen.
- R3: Any one of three inputs terminates a cycle: bit 0 of `size_ack`, bit 1 of `size_ack`, or `sync_term`. The strobe and termination may also arrive at the same edge, one clock after the cycle start.
- R4: If no address strobe is seen at the edge after a cycle start, `abort_flag` is high for one clock and `sample_en` stays low. If a new cycle start arrives at that same edge, a new cycle is opened and can still be sampled.
- R5: A termination that arrives after the strobe has dropped ends the cycle without raising `sample_en`.
- R6: A high `pipe_refill` at a rising edge sets `refill_flag`. The flag stays high through the next `sample_en` pulse and clears at the edge after that pulse.
- R7: A `pipe_status` pulse exactly one clock long sets `boundary_flag` at the edge where status is seen low again. The flag stays set until the edge after the next `sample_en` pulse.
- R8: A `pipe_status` pulse two or more clocks long sets `exception_flag` instead of `boundary_flag`, with the same set and clear timing as R7.
- R9: `halt_flag` rises after `TIMEOUT` rising edges spent in the strobed state with no termination. It clears at the edge after the cycle ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst | input | 1 | Processor reset, active high, synchronous |
| cyc_start | input | 1 | External cycle start |
| addr_strobe | input | 1 | Address strobe, high while the address is valid |
| size_ack | input | ACK_W | Asynchronous size acknowledge lines |
| sync_term | input | 1 | Synchronous termination |
| pipe_status | input | 1 | Execution-unit status line |
| pipe_refill | input | 1 | Pipeline refill marker |
| sample_en | output | 1 | Analyzer sample enable, one clock per completed cycle |
| abort_flag | output | 1 | One-clock pulse for a started but aborted cycle |
| refill_flag | output | 1 | Refill tag held until the next sample |
| boundary_flag | output | 1 | Instruction-boundary tag held until the next sample |
| exception_flag | output | 1 | Exception tag held until the next sample |
| halt_flag | output | 1 | Reset or bus-timeout halt qualifier |

## Verification
The bus-cycle machine is driven with four patterns:
- a slow cycle, where the strobe arrives and termination follows a clock later;
- a fast cycle, where the strobe and termination arrive together;
- a start that is never strobed;
- a start that is never strobed, immediately followed by a second start.

The slow and fast cycles separate the active→idle path from the started→idle path. The two unstrobed starts separate a plain abort from an abort that opens a new cycle. Each termination source is used on its own, which shows that no single line is the only one decoded. A termination after the strobe has dropped shows that sampling depends on the strobe and not only on termination. The status tests use a one-clock pulse and a three-clock pulse, which tell a boundary from an exception. A long stall, held until past `TIMEOUT` and then terminated, locates the halt edge to the exact clock and shows that the halt clears.

// File: rtl/trq_pkg.sv
package trq_pkg;

    typedef enum logic [1:0] {
        CYC_IDLE    = 2'd0,
        CYC_STARTED = 2'd1,
        CYC_ACTIVE  = 2'd2
    } cyc_state_e;

    typedef enum logic [1:0] {
        ST_QUIET = 2'd0,
        ST_ONE   = 2'd1,
        ST_MANY  = 2'd2
    } stat_state_e;

endpackage

// File: rtl/trq_cycle_fsm.sv
module trq_cycle_fsm
    import trq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cyc_start,
    input  logic addr_strobe,
    input  logic term,
    output logic sample_q,
    output logic abort_q,
    output logic bus_active
);

    cyc_state_e state, nxt;
    logic smp_d, abt_d;

    // next-state and output decode
    always_comb begin
        nxt   = state;
        smp_d = 1'b0;
        abt_d = 1'b0;
        unique case (state)
            CYC_IDLE: begin
                if (cyc_start) nxt = CYC_STARTED;
            end
            CYC_STARTED: begin
                if (addr_strobe) begin
                    if (term) begin
                        smp_d = 1'b1;
                        nxt   = CYC_IDLE;
                    end else begin
                        nxt = CYC_ACTIVE;
                    end
                end else begin
                    // started but never strobed: a cache hit took it
                    abt_d = 1'b1;
                    nxt   = cyc_start ? CYC_STARTED : CYC_IDLE;
                end
            end
            CYC_ACTIVE: begin
                if (term) begin
                    smp_d = addr_strobe;
                    nxt   = cyc_start ? CYC_STARTED : CYC_IDLE;
                end
            end
            default: nxt = CYC_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= CYC_IDLE;
        else     state <= nxt;
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            sample_q <= 1'b0;
            abort_q  <= 1'b0;
        end else begin
            sample_q <= smp_d;
            abort_q  <= abt_d;
        end
    end

    assign bus_active = (state == CYC_ACTIVE);

    p_sample_needs_strobe_r2: assert property (@(posedge clk) disable iff (rst)
        sample_q |-> ($past(addr_strobe) && $past(term)));

    p_abort_without_strobe_r4: assert property (@(posedge clk) disable iff (rst)
        abort_q |-> (!$past(addr_strobe) && !sample_q));

endmodule

// File: rtl/trq_event_tag.sv
module trq_event_tag
    import trq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic pipe_status,
    input  logic pipe_refill,
    input  logic sample_q,
    output logic refill_q,
    output logic boundary_q,
    output logic exception_q
);

    stat_state_e state, nxt;
    logic bnd_ev, exc_ev;

    // status pulse-length decode
    always_comb begin
        nxt    = state;
        bnd_ev = 1'b0;
        exc_ev = 1'b0;
        unique case (state)
            ST_QUIET: begin
                if (pipe_status) nxt = ST_ONE;
            end
            ST_ONE: begin
                if (pipe_status) begin
                    nxt = ST_MANY;
                end else begin
                    bnd_ev = 1'b1;
                    nxt    = ST_QUIET;
                end
            end
            ST_MANY: begin
                if (!pipe_status) begin
                    exc_ev = 1'b1;
                    nxt    = ST_QUIET;
                end
            end
            default: nxt = ST_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_QUIET;
        else     state <= nxt;
    end

    // tags hold until the analyzer has taken one sample carrying them
    always_ff @(posedge clk) begin
        if (rst) begin
            refill_q    <= 1'b0;
            boundary_q  <= 1'b0;
            exception_q <= 1'b0;
        end else begin
            refill_q    <= pipe_refill | (refill_q    & ~sample_q);
            boundary_q  <= bnd_ev      | (boundary_q  & ~sample_q);
            exception_q <= exc_ev      | (exception_q & ~sample_q);
        end
    end

    p_refill_captured_r6: assert property (@(posedge clk) disable iff (rst)
        $past(pipe_refill) |-> refill_q);

    p_boundary_short_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(boundary_q) |-> (!$past(pipe_status) && $past(pipe_status, 2)));

    p_exception_long_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(exception_q) |-> ($past(pipe_status, 2) && $past(pipe_status, 3)));

endmodule

// File: rtl/trq_halt_timer.sv
module trq_halt_timer #(
    parameter int TIMEOUT = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic bus_active,
    output logic halt_q
);

    localparam int CW = $clog2(TIMEOUT + 1);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            halt_q <= 1'b1;
        end else if (!bus_active) begin
            cnt    <= '0;
            halt_q <= 1'b0;
        end else if (cnt == LAST) begin
            halt_q <= 1'b1;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    p_halt_in_reset_r1: assert property (@(posedge clk)
        rst |=> halt_q);

    p_halt_only_when_stalled_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(halt_q) |-> $past(bus_active));

endmodule

// File: rtl/bus_trace_qualifier.sv
module bus_trace_qualifier #(
    parameter int TIMEOUT = 256,
    parameter int ACK_W   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cyc_start,
    input  logic             addr_strobe,
    input  logic [ACK_W-1:0] size_ack,
    input  logic             sync_term,
    input  logic             pipe_status,
    input  logic             pipe_refill,
    output logic             sample_en,
    output logic             abort_flag,
    output logic             refill_flag,
    output logic             boundary_flag,
    output logic             exception_flag,
    output logic             halt_flag
);

    logic term;
    logic bus_active;

    // R3: any acknowledge line or the synchronous termination ends a cycle
    assign term = (|size_ack) | sync_term;

    trq_cycle_fsm u_cycle (
        .clk         (clk),
        .rst         (rst),
        .cyc_start   (cyc_start),
        .addr_strobe (addr_strobe),
        .term        (term),
        .sample_q    (sample_en),
        .abort_q     (abort_flag),
        .bus_active  (bus_active)
    );

    trq_event_tag u_tag (
        .clk         (clk),
        .rst         (rst),
        .pipe_status (pipe_status),
        .pipe_refill (pipe_refill),
        .sample_q    (sample_en),
        .refill_q    (refill_flag),
        .boundary_q  (boundary_flag),
        .exception_q (exception_flag)
    );

    trq_halt_timer #(.TIMEOUT(TIMEOUT)) u_halt (
        .clk        (clk),
        .rst        (rst),
        .bus_active (bus_active),
        .halt_q     (halt_flag)
    );

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> !(sample_en || abort_flag || refill_flag || boundary_flag || exception_flag));

endmodule

// File: tb/bus_trace_qualifier_bench.sv
`timescale 1ns/1ps
module bus_trace_qualifier_bench;

    localparam int TO = 256;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cyc_start = 1'b0, addr_strobe = 1'b0, sync_term = 1'b0;
    logic pipe_status = 1'b0, pipe_refill = 1'b0;
    logic [1:0] size_ack = 2'b00;
    logic sample_en, abort_flag, refill_flag, boundary_flag, exception_flag, halt_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [5:0] exp;
        string      tag;
    } item_t;
    item_t q[$];

    always #2 clk = ~clk;

    bus_trace_qualifier #(.TIMEOUT(TO), .ACK_W(2)) u_bus_trace_qualifier (
        .clk(clk), .rst(rst), .cyc_start(cyc_start), .addr_strobe(addr_strobe),
        .size_ack(size_ack), .sync_term(sync_term), .pipe_status(pipe_status),
        .pipe_refill(pipe_refill), .sample_en(sample_en), .abort_flag(abort_flag),
        .refill_flag(refill_flag), .boundary_flag(boundary_flag),
        .exception_flag(exception_flag), .halt_flag(halt_flag)
    );

    // monitor: outputs settle just after the rising edge
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            item_t it;
            logic [5:0] got;
            it  = q.pop_front();
            got = {sample_en, abort_flag, refill_flag, boundary_flag, exception_flag, halt_flag};
            checks++;
            if (got !== it.exp) begin
                errors++;
                $display("FAIL %s: got %b expected %b (smp,abt,rfl,bnd,exc,hlt)", it.tag, got, it.exp);
            end
        end
    end

    // driver: apply one clock of inputs at the falling edge, queue the result expected after the next rising edge
    task automatic cyc(input logic cs, input logic as, input logic [1:0] ack, input logic st,
                       input logic stat, input logic rfl, input logic [5:0] exp, input string tag);
        cyc_start   = cs;
        addr_strobe = as;
        size_ack    = ack;
        sync_term   = st;
        pipe_status = stat;
        pipe_refill = rfl;
        q.push_back('{exp, tag});
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        cyc(0,0,2'b00,0,0,0, 6'b000001, "R1");
        rst = 1'b0;
        cyc(0,0,2'b00,0,0,0, 6'b000000, "R1");

        // R2 slow cycle ended by size_ack[0]
        cyc(1,0,2'b00,0,0,0, 6'b000000, "R2");
        cyc(0,1,2'b00,0,0,0, 6'b000000, "R2");
        cyc(0,1,2'b01,0,0,0, 6'b100000, "R2");
        cyc(0,0,2'b00,0,0,0, 6'b000000, "R2");

        // R3 size_ack[1]
        cyc(1,0,2'b00,0,0,0, 6'b000000, "R3");
        cyc(0,1,2'b00,0,0,0, 6'b000000, "R3");
        cyc(0,1,2'b10,0,0,0, 6'b100000, "R3");
        cyc(0,0,2'b00,0,0,0, 6'b000000, "R3");
        // R3 fast cycle ended by sync_term
        cyc(1,0,2'b00,0,0,0, 6'b000000, "R3");
        cyc(0,1,2'b00,1,0,0, 6'b100000, "R3");
        cyc(0,0,2'b00,0,0,0, 6'b000000, "R3");

        // R4 plain abort
        cyc(1,0,2'b00,0,0,0, 6'b000000, "R4");
        cyc(0,0,2'b00,0,0,0, 6'b010000, "R4");
        cyc(0,0,2'b00,0,0,0, 6'b000000, "R4");
        // R4 abort followed at once by a new start
        cyc(1,0,2'b00,0,0,0, 6'b000000, "R4");
        cyc(1,0,2'b00,0,0,0, 6'b010000, "R4");
        cyc(0,1,2'b01,0,0,0, 6'b100000, "R4");
        cyc(0,0,2'b00,0,0,0, 6'b000000, "R4");

        // R5 termination after strobe dropped
        cyc(1,0,2'b00,0,0,0, 6'b000000, "R5");
        cyc(0,1,2'b00,0,0,0, 6'b000000, "R5");
        cyc(0,0,2'b01,0,0,0, 6'b000000, "R5");
        cyc(0,0,2'b00,0,0,0, 6'b000000, "R5");

        // R6 refill held to the sample
        cyc(0,0,2'b00,0,0,1, 6'b001000, "R6");
        cyc(0,0,2'b00,0,0,0, 6'b001000, "R6");
        cyc(1,0,2'b00,0,0,0, 6'b001000, "R6");
        cyc(0,1,2'b00,0,0,0, 6'b001000, "R6");
        cyc(0,1,2'b01,0,0,0, 6'b101000, "R6");
        cyc(0,0,2'b00,0,0,0, 6'b000000, "R6");

        // R7 one-clock status -> boundary
        cyc(0,0,2'b00,0,1,0, 6'b000000, "R7");
        cyc(0,0,2'b00,0,0,0, 6'b000100, "R7");
        cyc(0,0,2'b00,0,0,0, 6'b000100, "R7");
        cyc(1,0,2'b00,0,0,0, 6'b000100, "R7");
        cyc(0,1,2'b00,1,0,0, 6'b100100, "R7");
        cyc(0,0,2'b00,0,0,0, 6'b000000, "R7");

        // R8 three-clock status -> exception
        cyc(0,0,2'b00,0,1,0, 6'b000000, "R8");
        cyc(0,0,2'b00,0,1,0, 6'b000000, "R8");
        cyc(0,0,2'b00,0,1,0, 6'b000000, "R8");
        cyc(0,0,2'b00,0,0,0, 6'b000010, "R8");
        cyc(1,0,2'b00,0,0,0, 6'b000010, "R8");
        cyc(0,1,2'b01,0,0,0, 6'b100010, "R8");
        cyc(0,0,2'b00,0,0,0, 6'b000000, "R8");

        // R9 stalled strobed cycle
        cyc(1,0,2'b00,0,0,0, 6'b000000, "R9");
        cyc(0,1,2'b00,0,0,0, 6'b000000, "R9");
        for (int k = 1; k <= TO + 2; k++)
            cyc(0,1,2'b00,0,0,0, (k >= TO) ? 6'b000001 : 6'b000000, "R9");
        cyc(0,1,2'b01,0,0,0, 6'b100001, "R9");
        cyc(0,0,2'b00,0,0,0, 6'b000000, "R9");
        cyc(0,0,2'b00,0,0,0, 6'b000000, "R9");

        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule